// File: doc/BRIEF.md
# Half to Single Precision Widener

This block turns a 16-bit half-precision bit pattern into the single-precision bit pattern that has exactly the same value. Every half value fits in single precision without loss, so there is no rounding and there are no exception flags. The result is a pure rearrangement of fields. The two cases that need more than a fixed re-wiring are subnormal halves and inputs with exponent 31. Subnormal halves are renormalized with a leading-zero count, so the result is always a normal single. For exponent 31, a per-word mode bit picks how it is read.

Data enters with an input valid and leaves two clock cycles later with an output valid. The input side accepts a new word on every cycle. The mode bit travels with its own word, so consecutive words may use different formats. Stage one classifies the word and counts the leading zeros of the mantissa. Stage two builds the 32-bit result.

Top module: `halfWiden`

## Requirements
- R1: Output bit 31 equals input bit 15 (the sign) for every input, including zeros, subnormals, infinities and NaNs.
- R2: For input exponent field bits [14:10] in 1..30, the output exponent field bits [30:23] equals the input exponent plus 112. Output bits [22:13] equal input bits [9:0], and output bits [12:0] are zero.
- R3: For input exponent 0 with a nonzero mantissa, let p be the bit index of the mantissa's highest set bit. The output exponent is p+103, and the output mantissa is (mantissa − 2^p) shifted left by 23−p. The result is always a normal single.
- R4: An input with bits [14:0] all zero produces output bits [30:0] all zero, with the sign kept.
- R5: With inAltMode = 0 (standard format), input exponent 31 gives output exponent 0xFF with input bits [9:0] placed in output bits [22:13]. Infinity therefore stays infinity, and a NaN keeps its payload.
- R6: With inAltMode = 1 (alternative format), input exponent 31 is a finite exponent: the output exponent is 0x8F and the mantissa is placed as in R2.
- R7: inAltMode is captured with its own data word and changes only the result of exponent-31 inputs. Back-to-back words may use different modes.
- R8: outValid is high exactly two cycles after each cycle in which inValid was high, and outData belongs to that input word. Words may arrive on every cycle or with gaps.
- R9: rst is synchronous and active high. While it is asserted, and on the cycle after it, outValid is low, and words in flight are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word present |
| inData | input | 16 | Half-precision bit pattern |
| inAltMode | input | 1 | 1: exponent 31 is finite; 0: exponent 31 is infinity/NaN |
| outValid | output | 1 | Result present |
| outData | output | 32 | Single-precision bit pattern |

## Verification
All 65,536 half patterns are streamed back to back, once in each mode. The mode pattern flips every two words, so a mode sampled from the wrong cycle changes the result at exponent 31. The sweep covers all ten subnormal shift amounts, which catches an off-by-one in the leading-zero count or the exponent offset. Directed words pin known values: one, the smallest subnormal, infinity, a NaN with payload, the largest alternative value and negative zero. These distinguish the infinity rule from the finite rule. A burst with idle gaps, followed by a reset taken while words are in flight, separates correct valid tracking from valid that leaks or gets stuck.

// File: rtl/hwPkg.sv
`timescale 1ns/1ps
package hwPkg;
  parameter int HALF_EXP_W = 5;
  parameter int HALF_MAN_W = 10;
  parameter int SGL_EXP_W  = 8;
  parameter int SGL_MAN_W  = 23;

  localparam int HALF_W   = 1 + HALF_EXP_W + HALF_MAN_W;
  localparam int SGL_W    = 1 + SGL_EXP_W + SGL_MAN_W;
  localparam int SHIFT_W  = $clog2(HALF_MAN_W + 1);
  localparam int LOW_PAD  = SGL_MAN_W - HALF_MAN_W;
  localparam int BIAS_GAP = ((1 << (SGL_EXP_W - 1)) - 1) - ((1 << (HALF_EXP_W - 1)) - 1);

  typedef enum logic [1:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_SPECIAL
  } inClass_e;

  typedef struct packed {
    logic s1Load;
    logic s2Load;
  } ctrlStrobes_t;

  typedef struct packed {
    logic                  sign;
    logic [HALF_EXP_W-1:0] exp;
    logic [HALF_MAN_W-1:0] man;
    inClass_e              cls;
    logic [SHIFT_W-1:0]    shift;
  } stageOne_t;
endpackage

// File: rtl/hwCtrl.sv
`timescale 1ns/1ps
module hwCtrl
  import hwPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output ctrlStrobes_t strobe,
  output logic         outValid
);
  logic valid1;
  logic valid2;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid1 <= 1'b0;
      valid2 <= 1'b0;
    end else begin
      valid1 <= inValid;
      valid2 <= valid1;
    end
  end

  always_comb begin
    strobe.s1Load = inValid;
    strobe.s2Load = valid1;
  end

  assign outValid = valid2;
endmodule

// File: rtl/hwDatapath.sv
`timescale 1ns/1ps
module hwDatapath
  import hwPkg::*;
(
  input  logic              clk,
  input  ctrlStrobes_t      strobe,
  input  logic [HALF_W-1:0] inData,
  input  logic              inAltMode,
  output logic [SGL_W-1:0]  outData
);
  logic [HALF_EXP_W-1:0] rawExp;
  logic [HALF_MAN_W-1:0] rawMan;
  logic [SHIFT_W-1:0]    leadShift;
  inClass_e              rawCls;
  stageOne_t             st1;

  assign rawExp = inData[HALF_W-2 -: HALF_EXP_W];
  assign rawMan = inData[HALF_MAN_W-1:0];

  // Priority encoder: distance that moves the highest set mantissa bit past the point
  always_comb begin
    logic found;
    found     = 1'b0;
    leadShift = '0;
    for (int i = HALF_MAN_W - 1; i >= 0; i--) begin
      if (!found && rawMan[i]) begin
        found     = 1'b1;
        leadShift = SHIFT_W'(HALF_MAN_W - i);
      end
    end
  end

  always_comb begin
    if (rawExp == '0)
      rawCls = (rawMan == '0) ? CLS_ZERO : CLS_SUB;
    else if ((rawExp == '1) && !inAltMode)
      rawCls = CLS_SPECIAL;
    else
      rawCls = CLS_NORM;
  end

  always_ff @(posedge clk) begin
    if (strobe.s1Load) begin
      st1.sign  <= inData[HALF_W-1];
      st1.exp   <= rawExp;
      st1.man   <= rawMan;
      st1.cls   <= rawCls;
      st1.shift <= leadShift;
    end
  end

  // Stage two: assemble the single-precision fields
  logic [SGL_EXP_W-1:0]  asmExp;
  logic [HALF_MAN_W-1:0] asmMan;

  always_comb begin
    unique case (st1.cls)
      CLS_ZERO: begin
        asmExp = '0;
        asmMan = '0;
      end
      CLS_SUB: begin
        asmExp = SGL_EXP_W'(BIAS_GAP + 1) - SGL_EXP_W'(st1.shift);
        asmMan = st1.man << st1.shift;
      end
      CLS_SPECIAL: begin
        asmExp = '1;
        asmMan = st1.man;
      end
      default: begin
        asmExp = SGL_EXP_W'(st1.exp) + SGL_EXP_W'(BIAS_GAP);
        asmMan = st1.man;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.s2Load)
      outData <= {st1.sign, asmExp, asmMan, {LOW_PAD{1'b0}}};
  end
endmodule

// File: rtl/halfWiden.sv
`timescale 1ns/1ps
module halfWiden
  import hwPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [15:0] inData,
  input  logic        inAltMode,
  output logic        outValid,
  output logic [31:0] outData
);
  ctrlStrobes_t strobe;

  hwCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  hwDatapath u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .inData    (inData),
    .inAltMode (inAltMode),
    .outData   (outData)
  );
endmodule

// File: rtl/hwChecker.sv
`timescale 1ns/1ps
module hwChecker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [15:0] inData,
  input logic        inAltMode,
  input logic        outValid,
  input logic [31:0] outData
);
  p_pipe_r8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid);

  p_novalid_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 2));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> !outValid);

  p_sign_r1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outData[31] == $past(inData[15], 2));

  p_lowzero_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outData[12:0] == 13'd0);

  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(inData[14:0], 2) == 15'd0) |-> outData[30:0] == 31'd0);

  p_special_r5: assert property (@(posedge clk) disable iff (rst)
    (outValid && !$past(inAltMode, 2) && $past(inData[14:10], 2) == 5'd31)
      |-> (outData[30:23] == 8'hFF && outData[22:13] == $past(inData[9:0], 2)));

  p_altexp_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(inAltMode, 2) && $past(inData[14:10], 2) == 5'd31)
      |-> outData[30:23] == 8'h8F);
endmodule

bind halfWiden hwChecker u_chk (.*);

// File: tb/sim_halfWiden.sv
`timescale 1ns/1ps
module sim_halfWiden;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        inAltMode = 1'b0;
  logic        outValid;
  logic [31:0] outData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic        hv0 = 1'b0, hv1 = 1'b0;
  logic [31:0] he0 = '0, he1 = '0;
  string       ht0 = "", ht1 = "";

  always #4 clk = ~clk;

  halfWiden u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inAltMode(inAltMode), .outValid(outValid), .outData(outData)
  );

  function automatic logic [31:0] refWord(input logic [15:0] h, input logic alt);
    logic       s;
    int         e, m, p;
    logic [7:0] ee;
    s = h[15];
    e = int'(h[14:10]);
    m = int'(h[9:0]);
    if (e == 0 && m == 0) return {s, 31'd0};
    if (e == 0) begin
      p = 0;
      for (int i = 0; i < 10; i++) if (m >= (1 << i)) p = i;
      ee = 8'(p + 103);
      return {s, ee, 23'((m - (1 << p)) << (23 - p))};
    end
    if (e == 31 && !alt) return {s, 8'hFF, h[9:0], 13'd0};
    ee = 8'(e + 112);
    return {s, ee, h[9:0], 13'd0};
  endfunction

  function automatic string tagOf(input logic [15:0] h, input logic alt);
    if (h[14:0] == 15'd0) return "R4";
    if (h[14:10] == 5'd0) return "R3";
    if (h[14:10] == 5'd31) return alt ? "R6" : "R5";
    return "R2";
  endfunction

  task automatic fail(input string tag, input logic [31:0] got, input logic [31:0] want);
    testsFailed++;
    $display("FAIL %s got %h expected %h", tag, got, want);
  endtask

  // One cycle: check the result of the word driven two cycles ago, then drive a new word
  task automatic step(input logic v, input logic [15:0] d, input logic alt,
                      input logic [31:0] want, input string tag);
    @(negedge clk);
    testsRun++;
    if (outValid !== hv1) fail("R8 valid", {31'd0, outValid}, {31'd0, hv1});
    else if (hv1) begin
      testsRun++;
      if (outData[31] !== he1[31]) fail("R1 sign", outData, he1);
      testsRun++;
      if (outData !== he1) fail(ht1, outData, he1);
    end
    hv1 = hv0; he1 = he0; ht1 = ht0;
    hv0 = v;   he0 = want; ht0 = tag;
    inValid   = v;
    inData    = d;
    inAltMode = alt;
  endtask

  task automatic sendRef(input logic [15:0] d, input logic alt);
    step(1'b1, d, alt, refWord(d, alt), tagOf(d, alt));
  endtask

  task automatic idle();
    step(1'b0, 16'h0, 1'b0, 32'h0, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testsRun++;
    if (outValid !== 1'b0) fail("R9 reset", {31'd0, outValid}, 32'd0);
    rst = 1'b0;

    // Directed words with hand-derived results
    step(1'b1, 16'h3C00, 1'b0, 32'h3F800000, "R2 one");
    step(1'b1, 16'h0001, 1'b0, 32'h33800000, "R3 smallest subnormal");
    step(1'b1, 16'h0200, 1'b1, 32'h38000000, "R3 largest-shift-one subnormal");
    step(1'b1, 16'h7C00, 1'b0, 32'h7F800000, "R5 infinity");
    step(1'b1, 16'h7E01, 1'b0, 32'h7FC02000, "R5 NaN payload");
    step(1'b1, 16'h7FFF, 1'b1, 32'h47FFE000, "R6 largest alternative");
    step(1'b1, 16'h8000, 1'b1, 32'h80000000, "R4 negative zero");
    idle();
    step(1'b1, 16'hFC00, 1'b1, 32'hC7800000, "R7 alt mode word");
    idle();
    idle();
    step(1'b1, 16'hFC00, 1'b0, 32'hFF800000, "R7 standard mode word");
    step(1'b1, 16'h7C00, 1'b1, 32'h47800000, "R7 mode flips next word");
    idle();
    idle();

    // Full sweeps, mode flipping every two words, then the complementary pattern
    for (int i = 0; i < 65536; i++) sendRef(16'(i), logic'(i[1]));
    for (int i = 0; i < 65536; i++) sendRef(16'(i), logic'(~i[1]));
    idle();
    idle();
    idle();

    // R9: reset while a word is in flight drops it
    @(negedge clk);
    inValid = 1'b1; inData = 16'h3C00;
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      testsRun++;
      if (outValid !== 1'b0) fail("R9 flush", {31'd0, outValid}, 32'd0);
    end
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      testsRun++;
      if (outValid !== 1'b0) fail("R9 stays idle", {31'd0, outValid}, 32'd0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsFailed++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule